// File: doc/BRIEF.md
# COBS Stream Frame Decoder

This block turns a stream of bytes stuffed with Consistent Overhead Byte Stuffing back into payload bytes. A typical source is a UART receiver. Each accepted byte arrives with a one-cycle valid strobe. A separate overrun input flags that the source has lost data. Each decoded payload byte leaves the block as a write strobe, a buffer position and a data byte. The write goes straight into a receive buffer owned by the next protocol layer. Every 0x00 byte on the stream marks a frame boundary. At a boundary the block pulses a frame-complete strobe and reports how many payload bytes it wrote, which can be zero.

The decoder has three phases:
- **Discard**: it waits for a delimiter and drops every non-zero byte.
- **Expect-code**: it takes the next non-zero byte as the first code byte.
- **Payload**: it counts code intervals and turns the byte that ends each interval into a 0x00.

An overrun or an over-long frame sends the decoder back to the discard phase, so it realigns on the next delimiter. Two saturating event counters record overruns and over-long frames.

Top module: `cobs_rx_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, the outputs `wr_en`, `frame_done` and `frame_invalid` are 0 and both event counters are 0. After reset the decoder is in the discard phase.
- R2: An accepted byte equal to 0x00 with `in_overrun` low is a delimiter, in every phase. On the next cycle `frame_done` is high for one cycle and `frame_len` equals the number of payload writes since the position was last cleared. The delimiter clears the position to 0 and moves the decoder to the expect-code phase.
- R3: In the discard phase, a non-zero byte produces no write, no `frame_done` and no `frame_invalid`.
- R4: In the expect-code phase, a non-zero byte produces no write. Its value loads the interval counter and the decoder moves to the payload phase.
- R5: In the payload phase, each byte gives exactly one write on the next cycle. `wr_addr` starts at 0 and counts up by one per write. Each byte decrements the interval counter. If the counter reaches zero, the byte written is 0x00 and the counter reloads with the received value. Otherwise the received value is written unchanged.
- R6: The stream 03 11 22 02 33 00 writes 11 22 00 33 and reports length 4. The stream 01 01 00 writes a single 00 and reports length 1. The stream 05 11 22 33 44 00 writes 11 22 33 44 and reports length 4.
- R7: `in_overrun` takes priority over the byte offered in the same cycle, which is then dropped without any write or strobe. The overrun clears the position, forces the discard phase and adds one to `overrun_count`.
- R8: A frame can hold at most MAX_LEN payload bytes (254 by default), at positions 0 to MAX_LEN-1, and a full frame is reported with length MAX_LEN. If a payload byte arrives when MAX_LEN bytes are already written, it is not written. Instead, `frame_invalid` pulses on the next cycle, `invalid_count` rises by one, the position clears and the decoder enters the discard phase.
- R9: `overrun_count` and `invalid_count` hold at their all-ones value instead of wrapping.
- R10: A cycle with `in_valid` and `in_overrun` both low changes nothing and gives no write or strobe on the next cycle.
- R11: A frame with no payload (a code byte 01 followed by the delimiter, or two adjacent delimiters) is reported with length 0 and no writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stream byte is offered this cycle |
| in_data | input | 8 | Stream byte |
| in_overrun | input | 1 | Source lost data; forces resynchronization |
| wr_en | output | 1 | Decoded byte write strobe |
| wr_addr | output | POS_W (8) | Position of the decoded byte within the frame |
| wr_data | output | 8 | Decoded byte |
| frame_done | output | 1 | One-cycle pulse on every delimiter |
| frame_len | output | POS_W (8) | Payload length reported with `frame_done` |
| frame_invalid | output | 1 | One-cycle pulse when a frame exceeds MAX_LEN |
| overrun_count | output | CNT_W (8) | Saturating count of overrun events |
| invalid_count | output | CNT_W (8) | Saturating count of over-long frames |

## Verification
The checker tests these properties on every cycle:
- Each delimiter is followed by `frame_done`.
- A cycle with an overrun or with no stream byte produces no write or strobe.
- Write positions stay below MAX_LEN.
- At most one of write, done and invalid is active at a time.
- Overrun counting and counter saturation behave as required.

The value side of decoding can only be shown by the scenarios that feed whole frames and compare the written buffer contents and the reported lengths. This covers:
- substituting 0x00 where a code interval ends;
- discarding bytes before the first delimiter and after an overrun;
- the exact boundary between a full 254-byte frame and a rejected one.

// File: rtl/cobs_pkg.sv
package cobs_pkg;

    localparam logic [7:0] COBS_DELIM = 8'h00;

    typedef enum logic [1:0] {
        PH_DISCARD = 2'd0,
        PH_CODE    = 2'd1,
        PH_PAYLOAD = 2'd2
    } cobs_phase_e;

endpackage

// File: rtl/cobs_core.sv
module cobs_core
    import cobs_pkg::*;
#(
    parameter int MAX_LEN = 254,
    parameter int POS_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_overrun,
    output logic             wr_en,
    output logic [POS_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             frame_done,
    output logic [POS_W-1:0] frame_len,
    output logic             frame_invalid
);

    localparam logic [POS_W-1:0] POS_LIMIT = POS_W'(MAX_LEN);

    typedef struct packed {
        cobs_phase_e      phase;
        logic [7:0]       skip;
        logic [POS_W-1:0] pos;
        logic             wr;
        logic [POS_W-1:0] addr;
        logic [7:0]       data;
        logic             done;
        logic [POS_W-1:0] len;
        logic             inv;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wr   = 1'b0;
        st_d.done = 1'b0;
        st_d.inv  = 1'b0;
        if (in_overrun) begin
            st_d.phase = PH_DISCARD;
            st_d.pos   = '0;
        end else if (in_valid) begin
            if (in_data == COBS_DELIM) begin
                st_d.done  = 1'b1;
                st_d.len   = st_q.pos;
                st_d.pos   = '0;
                st_d.phase = PH_CODE;
            end else begin
                unique case (st_q.phase)
                    PH_DISCARD: begin
                        st_d.phase = PH_DISCARD;
                    end
                    PH_CODE: begin
                        st_d.skip  = in_data;
                        st_d.phase = PH_PAYLOAD;
                    end
                    default: begin
                        if (st_q.pos == POS_LIMIT) begin
                            st_d.inv   = 1'b1;
                            st_d.pos   = '0;
                            st_d.phase = PH_DISCARD;
                        end else begin
                            st_d.wr   = 1'b1;
                            st_d.addr = st_q.pos;
                            st_d.pos  = st_q.pos + 1'b1;
                            if (st_q.skip == 8'd1) begin
                                st_d.data = 8'h00;
                                st_d.skip = in_data;
                            end else begin
                                st_d.data = in_data;
                                st_d.skip = st_q.skip - 8'd1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_DISCARD;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en         = st_q.wr;
    assign wr_addr       = st_q.addr;
    assign wr_data       = st_q.data;
    assign frame_done    = st_q.done;
    assign frame_len     = st_q.len;
    assign frame_invalid = st_q.inv;

endmodule

// File: rtl/cobs_sat_counter.sv
module cobs_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hit && cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/cobs_rx_decoder.sv
module cobs_rx_decoder #(
    parameter int MAX_LEN = 254,
    parameter int CNT_W   = 8,
    localparam int POS_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_overrun,
    output logic             wr_en,
    output logic [POS_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             frame_done,
    output logic [POS_W-1:0] frame_len,
    output logic             frame_invalid,
    output logic [CNT_W-1:0] overrun_count,
    output logic [CNT_W-1:0] invalid_count
);

    localparam int N_EVT = 2;

    logic             inv_pulse;
    logic [N_EVT-1:0] evt;
    logic [CNT_W-1:0] evt_cnt [N_EVT];

    cobs_core #(
        .MAX_LEN (MAX_LEN),
        .POS_W   (POS_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_overrun    (in_overrun),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .frame_done    (frame_done),
        .frame_len     (frame_len),
        .frame_invalid (inv_pulse)
    );

    assign frame_invalid = inv_pulse;
    assign evt           = {inv_pulse, in_overrun};

    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
        cobs_sat_counter #(
            .W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (evt[g]),
            .count (evt_cnt[g])
        );
    end

    assign overrun_count = evt_cnt[0];
    assign invalid_count = evt_cnt[1];

endmodule

// File: rtl/cobs_rx_checker.sv
module cobs_rx_checker #(
    parameter int MAX_LEN = 254,
    parameter int CNT_W   = 8,
    localparam int POS_W  = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic             in_overrun,
    input logic             wr_en,
    input logic [POS_W-1:0] wr_addr,
    input logic             frame_done,
    input logic             frame_invalid,
    input logic [CNT_W-1:0] overrun_count,
    input logic [CNT_W-1:0] invalid_count
);

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < MAX_LEN));

    a_r2_delim_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == 8'h00 && !in_overrun) |=> frame_done);

    a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, frame_done, frame_invalid}));

    a_r7_overrun_silent: assert property (@(posedge clk) disable iff (!rst_n)
        in_overrun |=> (!wr_en && !frame_done && !frame_invalid));

    a_r7_overrun_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_overrun && overrun_count != FULL) |=> (overrun_count == $past(overrun_count) + 1'b1));

    a_r9_overrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_count == FULL) |=> (overrun_count == FULL));

    a_r9_invalid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_count == FULL) |=> (invalid_count == FULL));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !in_overrun) |=> (!wr_en && !frame_done && !frame_invalid));

endmodule

bind cobs_rx_decoder cobs_rx_checker #(
    .MAX_LEN (MAX_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_overrun    (in_overrun),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .frame_done    (frame_done),
    .frame_invalid (frame_invalid),
    .overrun_count (overrun_count),
    .invalid_count (invalid_count)
);

// File: tb/cobs_rx_decoder_tb.sv
module cobs_rx_decoder_tb;

    localparam int MAX_LEN = 254;
    localparam int CNT_W   = 3;
    localparam int POS_W   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             in_overrun = 1'b0;
    logic             wr_en;
    logic [POS_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic             frame_done;
    logic [POS_W-1:0] frame_len;
    logic             frame_invalid;
    logic [CNT_W-1:0] overrun_count;
    logic [CNT_W-1:0] invalid_count;

    cobs_rx_decoder #(
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_overrun    (in_overrun),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .frame_done    (frame_done),
        .frame_len     (frame_len),
        .frame_invalid (frame_invalid),
        .overrun_count (overrun_count),
        .invalid_count (invalid_count)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    int         wcnt = 0;
    int         dcnt = 0;
    int         icnt = 0;
    int         last_len = -1;
    logic [7:0] wdat [0:511];
    int         waddr [0:511];

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (wcnt < 512) begin
                    wdat[wcnt]  = wr_data;
                    waddr[wcnt] = int'(wr_addr);
                end
                wcnt++;
            end
            if (frame_done) begin
                dcnt++;
                last_len = int'(frame_len);
            end
            if (frame_invalid) icnt++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        wcnt = 0; dcnt = 0; icnt = 0; last_len = -1;
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic overrun_pulse();
        in_overrun = 1'b1;
        in_valid   = 1'b1;
        in_data    = 8'h00;
        @(negedge clk);
        in_overrun = 1'b0;
        in_valid   = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic t_reset();
        chk("R1 wr_en in reset", int'(wr_en), 0);
        chk("R1 frame_done in reset", int'(frame_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 frame_invalid after reset", int'(frame_invalid), 0);
        chk("R1 overrun_count after reset", int'(overrun_count), 0);
        chk("R1 invalid_count after reset", int'(invalid_count), 0);
        clr();
        send(8'h55); send(8'h66); send(8'h03);
        settle();
        chk("R3 discard phase writes", wcnt, 0);
        chk("R3 discard phase done", dcnt, 0);
        chk("R3 discard phase invalid", icnt, 0);
    endtask

    task automatic t_first_delim();
        clr();
        send(8'h00);
        settle();
        chk("R2 delimiter after sync done", dcnt, 1);
        chk("R11 empty sync length", last_len, 0);
    endtask

    task automatic t_example_a();
        clr();
        send(8'h03); send(8'h11); send(8'h22); send(8'h02); send(8'h33); send(8'h00);
        settle();
        chk("R6 ex A writes", wcnt, 4);
        chk("R6 ex A byte0", int'(wdat[0]), 'h11);
        chk("R6 ex A byte1", int'(wdat[1]), 'h22);
        chk("R5 interval end gives zero", int'(wdat[2]), 'h00);
        chk("R6 ex A byte3", int'(wdat[3]), 'h33);
        chk("R5 addr 0", waddr[0], 0);
        chk("R5 addr 3", waddr[3], 3);
        chk("R6 ex A length", last_len, 4);
        chk("R2 ex A done count", dcnt, 1);
    endtask

    task automatic t_example_b();
        clr();
        send(8'h01); send(8'h01); send(8'h00);
        settle();
        chk("R6 ex B writes", wcnt, 1);
        chk("R6 ex B byte", int'(wdat[0]), 'h00);
        chk("R6 ex B length", last_len, 1);
    endtask

    task automatic t_plain_gaps();
        clr();
        send(8'h05);
        settle();
        chk("R4 code byte no write", wcnt, 0);
        send(8'h11); @(negedge clk); send(8'h22); settle();
        send(8'h33); @(negedge clk); @(negedge clk); send(8'h44);
        settle(); settle();
        chk("R10 gaps add no writes", wcnt, 4);
        chk("R10 gaps add no done", dcnt, 0);
        send(8'h00);
        settle();
        chk("R6 ex C byte3", int'(wdat[3]), 'h44);
        chk("R6 ex C addr3", waddr[3], 3);
        chk("R6 ex C length", last_len, 4);
    endtask

    task automatic t_empty();
        clr();
        send(8'h01); send(8'h00);
        settle();
        chk("R11 code 01 writes", wcnt, 0);
        chk("R11 code 01 length", last_len, 0);
        clr();
        send(8'h00);
        settle();
        chk("R11 double delimiter length", last_len, 0);
        chk("R11 double delimiter done", dcnt, 1);
    endtask

    task automatic t_overrun();
        clr();
        send(8'h03); send(8'h11);
        overrun_pulse();
        send(8'h22); send(8'h04);
        settle();
        chk("R7 overrun drops delimiter", dcnt, 0);
        chk("R7 discard after overrun", wcnt, 1);
        chk("R7 overrun counted", int'(overrun_count), 1);
        send(8'h00);
        settle();
        chk("R7 position cleared", last_len, 0);
    endtask

    task automatic t_full_frame();
        clr();
        send(8'hFF);
        for (int i = 0; i < MAX_LEN; i++) send(8'h55);
        send(8'h00);
        settle();
        chk("R8 full frame writes", wcnt, MAX_LEN);
        chk("R8 full frame last addr", waddr[MAX_LEN-1], MAX_LEN - 1);
        chk("R8 full frame last data", int'(wdat[MAX_LEN-1]), 'h55);
        chk("R8 full frame length", last_len, MAX_LEN);
        chk("R8 full frame no invalid", icnt, 0);
    endtask

    task automatic t_too_long();
        clr();
        send(8'hFF);
        for (int i = 0; i < MAX_LEN; i++) send(8'h55);
        send(8'h77); send(8'h33);
        settle();
        chk("R8 excess byte not written", wcnt, MAX_LEN);
        chk("R8 invalid pulse", icnt, 1);
        chk("R8 invalid counted", int'(invalid_count), 1);
        send(8'h00);
        settle();
        chk("R8 resync length", last_len, 0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 8; i++) overrun_pulse();
        settle();
        chk("R9 overrun saturates", int'(overrun_count), 7);
        for (int i = 0; i < 7; i++) begin
            send(8'h00); send(8'hFF);
            for (int k = 0; k <= MAX_LEN; k++) send(8'h55);
        end
        settle();
        chk("R9 invalid saturates", int'(invalid_count), 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_first_delim();
        t_example_a();
        t_example_b();
        t_plain_gaps();
        t_empty();
        t_overrun();
        send(8'h00);
        settle();
        t_full_frame();
        t_too_long();
        t_saturate();
        summary();
    end

endmodule